// File: doc/BRIEF.md
# SPI Master Channel Transfer Engine

This block is a single SPI master channel, meant to be instantiated once per chip select. Software reaches it through a small register port (configuration, control, status, transmit and receive words). Each transmit word or receive read asks the channel to move one word. A start gate looks at the transmit-empty and receive-full flags together with the selected transfer mode (full duplex, receive-only, transmit-only, with an optional turbo setting). The gate decides whether the word may go. When it goes, a divider-clocked shifter moves it MSB first in SPI mode 0 while the chip select stays low.

At the end of each word the flags are updated. The channel raises level DMA requests for the transmit and receive sides, gated by the mode. It also produces one-cycle event pulses toward an external interrupt block. A module-level single-channel input can suppress the wire activity. In that case the flags still advance unless the per-channel force bit is set.

Top module: `spi_chan_engine`

## Requirements
- R1: After reset the status word reads 0x2, the configuration reads 0x060000, control reads 0, both DMA requests are low, cs_n is high and sclk is low.
- R2: Register addresses are 0 config, 1 status, 2 control, 3 transmit and 4 receive. Config keeps bits 22:0 and reads back with the upper bits zero. Config holds the clock divider in bits 5:2, the word-length code WL in bits 11:7 (the word is WL+1 bits), the mode in bits 13:12 (0 duplex, 1 receive-only, 2 transmit-only), the transmit DMA enable in bit 14, the receive DMA enable in bit 15, turbo in bit 19 and force in bit 20. Status bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is end-of-transfer.
- R3: Control bit 0 enables the channel. No word starts while it is clear, and a write that changes it from 0 to 1 makes a transfer attempt.
- R4: A transmit write stores the word, clears transmit-empty and makes an attempt. A strobed receive read returns the stored word, clears receive-full and makes an attempt.
- R5: An attempt is refused while receive-full is set with the mode not transmit-only and turbo clear. It is also refused while transmit-empty is set with the mode not receive-only.
- R6: End-of-transfer clears when a word starts. When the word finishes, the transmit register becomes 0, end-of-transfer and transmit-empty set, and receive-full sets unless the mode is transmit-only.
- R7: A wire transfer drives cs_n low for the whole word and shifts WL+1 bits MSB first. sclk idles low, MOSI changes only while sclk is low, and each sclk phase lasts divider+1 clock cycles.
- R8: The received bits land right-aligned in the receive register with zeros above them. In transmit-only mode the receive register keeps its old value.
- R9: With the single-channel input high and force clear, a started word produces no cs_n or sclk activity and leaves the receive register unchanged, but the flags update as in R6.
- R10: The transmit DMA request is enable AND bit 14 AND transmit-empty AND mode not 1. The receive DMA request is enable AND bit 15 AND receive-full AND mode not 2.
- R11: tx_empty_evt pulses for one cycle when (transmit-empty AND mode not 1) becomes true. rx_full_evt pulses for one cycle when (receive-full AND mode not 2 AND turbo clear) becomes true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only on receive address) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| solo_mode | input | 1 | Module-level single-channel select |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_empty_evt | output | 1 | Transmit-empty event pulse |
| rx_full_evt | output | 1 | Receive-full event pulse |

## Verification
The bench builds the channel with the default 32-bit word path and a 4-bit divider field. This lets a 32-bit word (WL=31) exercise the full shift with no alignment shift, while 8-, 12- and 16-bit words exercise left alignment of the transmit word and right alignment of the received word. It programs a divider of 1 so that each sclk phase is two cycles long; the phase width is then measured and not merely assumed. A bench-side slave returns a word that differs from the transmitted one, so a loopback or bit-order fault shows up in the received value.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

    localparam int CFG_W     = 23;
    localparam int WL_W      = 5;
    localparam int DIV_LO    = 2;
    localparam int WL_LO     = 7;
    localparam int MODE_LO   = 12;
    localparam int TXDMA_BIT = 14;
    localparam int RXDMA_BIT = 15;
    localparam int TURBO_BIT = 19;
    localparam int FORCE_BIT = 20;

    localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;

    typedef enum logic [1:0] {
        XFER_BOTH   = 2'd0,
        XFER_RXONLY = 2'd1,
        XFER_TXONLY = 2'd2,
        XFER_BAD    = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        RA_CFG  = 3'd0,
        RA_STAT = 3'd1,
        RA_CTL  = 3'd2,
        RA_TX   = 3'd3,
        RA_RX   = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && (cnt_q != div)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] word,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start && !q.busy) begin
            d.busy  = 1'b1;
            d.sclk  = 1'b0;
            d.cnt   = '0;
            d.tx_sh = word << (DATA_W - int'(nbits));
            d.rx_sh = '0;
        end else if (q.busy && tick) begin
            if (!q.sclk) begin
                d.sclk  = 1'b1;
                d.rx_sh = {q.rx_sh[DATA_W-2:0], miso};
            end else begin
                d.sclk = 1'b0;
                if (q.cnt == nbits - 1'b1) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.cnt   = q.cnt + 1'b1;
                    d.tx_sh = {q.tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign sclk    = q.sclk;
    assign mosi    = q.busy & q.tx_sh[DATA_W-1];
    assign done    = q.done;
    assign rx_word = q.rx_sh;

endmodule

// File: rtl/spi_start_gate.sv
module spi_start_gate
    import spi_chan_pkg::*;
(
    input  xfer_mode_e mode,
    input  logic       turbo,
    input  logic       en,
    input  logic       rxs,
    input  logic       txs,
    input  logic       txdma_en,
    input  logic       rxdma_en,
    output logic       blocked,
    output logic       tx_cond,
    output logic       rx_cond,
    output logic       tx_dreq,
    output logic       rx_dreq
);

    always_comb begin
        rx_cond = rxs && (mode != XFER_TXONLY) && !turbo;
        tx_cond = txs && (mode != XFER_RXONLY);
        blocked = rx_cond || tx_cond;
        tx_dreq = en && txdma_en && txs && (mode != XFER_RXONLY);
        rx_dreq = en && rxdma_en && rxs && (mode != XFER_TXONLY);
    end

endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine
    import spi_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        solo_mode,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso,
    output logic        tx_dreq,
    output logic        rx_dreq,
    output logic        tx_empty_evt,
    output logic        rx_full_evt
);

    localparam int CNT_W = $clog2(DATA_W) + 1;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic              en;
        logic              rxs;
        logic              txs;
        logic              eot;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic              attempt;
        logic              tx_prev;
        logic              rx_prev;
    } st_t;

    st_t st_d, st_q;

    xfer_mode_e        mode;
    logic              turbo, wire_ok, blocked, tx_cond, rx_cond;
    logic              launch, sh_start, sh_busy, sh_done, tick;
    logic [CNT_W-1:0]  nbits;
    logic [DATA_W-1:0] sh_rx;

    assign mode    = xfer_mode_e'(st_q.cfg[MODE_LO +: 2]);
    assign turbo   = st_q.cfg[TURBO_BIT];
    assign wire_ok = !solo_mode || st_q.cfg[FORCE_BIT];
    assign nbits   = CNT_W'(st_q.cfg[WL_LO +: WL_W]) + CNT_W'(1);

    spi_start_gate u_gate (
        .mode     (mode),
        .turbo    (turbo),
        .en       (st_q.en),
        .rxs      (st_q.rxs),
        .txs      (st_q.txs),
        .txdma_en (st_q.cfg[TXDMA_BIT]),
        .rxdma_en (st_q.cfg[RXDMA_BIT]),
        .blocked  (blocked),
        .tx_cond  (tx_cond),
        .rx_cond  (rx_cond),
        .tx_dreq  (tx_dreq),
        .rx_dreq  (rx_dreq)
    );

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_busy),
        .div   (st_q.cfg[DIV_LO +: DIV_W]),
        .tick  (tick)
    );

    spi_word_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .word    (st_q.tx),
        .nbits   (nbits),
        .tick    (tick),
        .miso    (miso),
        .busy    (sh_busy),
        .sclk    (sclk),
        .mosi    (mosi),
        .done    (sh_done),
        .rx_word (sh_rx)
    );

    assign cs_n = !sh_busy;

    always_comb begin
        logic finish;
        st_d         = st_q;
        st_d.attempt = 1'b0;
        st_d.tx_prev = tx_cond;
        st_d.rx_prev = rx_cond;

        launch   = st_q.attempt && st_q.en && !blocked && !sh_busy;
        sh_start = launch && wire_ok;
        finish   = (launch && !wire_ok) || sh_done;

        if (launch) begin
            st_d.eot = 1'b0;
        end
        if (finish) begin
            st_d.tx  = '0;
            st_d.eot = 1'b1;
            st_d.txs = 1'b1;
            if (mode != XFER_TXONLY) begin
                st_d.rxs = 1'b1;
                if (sh_done) begin
                    st_d.rx = sh_rx;
                end
            end
        end

        if (reg_wr) begin
            case (reg_addr)
                RA_CFG: st_d.cfg = reg_wdata[CFG_W-1:0];
                RA_CTL: begin
                    st_d.en = reg_wdata[0];
                    if (reg_wdata[0] && !st_q.en) begin
                        st_d.attempt = 1'b1;
                    end
                end
                RA_TX: begin
                    st_d.tx      = reg_wdata[DATA_W-1:0];
                    st_d.txs     = 1'b0;
                    st_d.attempt = 1'b1;
                end
                default: ;
            endcase
        end
        if (reg_rd && (reg_addr == RA_RX)) begin
            st_d.rxs     = 1'b0;
            st_d.attempt = 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CFG:  reg_rdata = 32'(st_q.cfg);
            RA_STAT: reg_rdata = {29'd0, st_q.eot, st_q.txs, st_q.rxs};
            RA_CTL:  reg_rdata = {31'd0, st_q.en};
            RA_TX:   reg_rdata = 32'(st_q.tx);
            RA_RX:   reg_rdata = 32'(st_q.rx);
            default: reg_rdata = '0;
        endcase
    end

    assign tx_empty_evt = tx_cond && !st_q.tx_prev;
    assign rx_full_evt  = rx_cond && !st_q.rx_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_RST, txs: 1'b1, tx_prev: 1'b1, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_chan_engine_chk.sv
module spi_chan_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic tx_empty_evt,
    input logic rx_full_evt,
    input logic en_q,
    input logic txs_q
);

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);  // R7

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));  // R7

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(en_q));  // R3

    AST_END_SETS_TXS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> txs_q);  // R6

    AST_TXEVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_evt |=> !tx_empty_evt);  // R11

    AST_RXEVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_evt |=> !rx_full_evt);  // R11

endmodule

bind spi_chan_engine spi_chan_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .mosi         (mosi),
    .tx_empty_evt (tx_empty_evt),
    .rx_full_evt  (rx_full_evt),
    .en_q         (st_q.en),
    .txs_q        (st_q.txs)
);

// File: tb/sim_spi_chan_engine.sv
`timescale 1ns/1ps
module sim_spi_chan_engine;

    localparam int PERIOD = 10;
    localparam int DIVV   = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        solo_mode = 1'b0;
    logic        sclk, cs_n, mosi, miso;
    logic        tx_dreq, rx_dreq, tx_empty_evt, rx_full_evt;

    always #(PERIOD/2) clk = ~clk;

    spi_chan_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .solo_mode(solo_mode), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
        .tx_empty_evt(tx_empty_evt), .rx_full_evt(rx_full_evt)
    );

    // slave model
    logic [31:0] slv_word = '0, slv_sh = '0, got = '0;
    int          slv_n = 8;
    int          rise_cnt = 0, fall_cs = 0, hi_cyc = 0, txe_cnt = 0, rxf_cnt = 0;

    always @(negedge cs_n) begin
        slv_sh  = slv_word;
        got     = '0;
        fall_cs = fall_cs + 1;
    end
    always @(negedge sclk) if (!cs_n) slv_sh = slv_sh << 1;
    always @(posedge sclk) begin
        got      = {got[30:0], mosi};
        rise_cnt = rise_cnt + 1;
    end
    always @(posedge clk) begin
        if (sclk)         hi_cyc  <= hi_cyc + 1;
        if (tx_empty_evt) txe_cnt <= txe_cnt + 1;
        if (rx_full_evt)  rxf_cnt <= rxf_cnt + 1;
    end
    assign miso = slv_sh[slv_n-1];

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_rx(output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'd4;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            peek(3'd1, s);
            if (s[2] && cs_n) break;
        end
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  mode;
        logic        solo;
        logic        frc;
        logic [4:0]  wl;
        logic [31:0] tx;
        logic [31:0] slv;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b0, 1'b0, 5'd7,  32'h000000A5, 32'h0000003C},
        '{2'd0, 1'b0, 1'b0, 5'd15, 32'h00001234, 32'h0000BEEF},
        '{2'd2, 1'b0, 1'b0, 5'd7,  32'h00000081, 32'h00000055},
        '{2'd1, 1'b0, 1'b0, 5'd11, 32'h00000000, 32'h00000ABC},
        '{2'd0, 1'b1, 1'b0, 5'd7,  32'h00000077, 32'h000000EE},
        '{2'd0, 1'b1, 1'b1, 5'd31, 32'hDEADBEEF, 32'h12345678}
    };

    function automatic logic [31:0] mk_mask(input int nb);
        logic [63:0] m;
        m = (64'd1 << nb) - 64'd1;
        return m[31:0];
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, prev_rx;
        int r0, f0, h0, t0, x0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd1, v); check("R1 status", v, 32'h2);
        peek(3'd0, v); check("R1 config", v, 32'h060000);
        peek(3'd2, v); check("R1 control", v, 32'h0);
        check("R1 dreqs", {30'd0, tx_dreq, rx_dreq}, 32'h0);
        check("R1 pins", {30'd0, cs_n, sclk}, 32'h2);

        // R2 config readback width
        wr(3'd0, 32'hFFFF_FFFF);
        peek(3'd0, v); check("R2 cfg readback", v, 32'h007F_FFFF);

        // vector table walk
        prev_rx = '0;
        foreach (VECS[i]) begin
            vec_t vc;
            int nb;
            logic wired;
            logic [31:0] m, exp_rx, exp_got;
            vc    = VECS[i];
            nb    = int'(vc.wl) + 1;
            m     = mk_mask(nb);
            wired = !vc.solo || vc.frc;
            wr(3'd2, 32'h0);
            rd_rx(v);
            solo_mode = vc.solo;
            slv_word  = vc.slv;
            slv_n     = nb;
            wr(3'd0, (32'(vc.frc) << 20) | (32'h3 << 14) | (32'(vc.mode) << 12) |
                     (32'(vc.wl) << 7) | (32'(DIVV) << 2));
            r0 = rise_cnt; h0 = hi_cyc; f0 = fall_cs;
            wr(3'd2, 32'h1);
            if (vc.mode != 2'd1) wr(3'd3, vc.tx);
            wait_done();
            exp_rx  = (wired && vc.mode != 2'd2) ? (vc.slv & m) : prev_rx;
            exp_got = (vc.mode == 2'd1) ? 32'h0 : (vc.tx & m);
            peek(3'd4, v); check("R8 rx word", v, exp_rx);
            peek(3'd1, v); check("R6 status after word", v, {29'd0, 1'b1, 1'b1, vc.mode != 2'd2});
            peek(3'd3, v); check("R6 tx cleared", v, 32'h0);
            check("R7 sclk rises", 32'(rise_cnt - r0), wired ? 32'(nb) : 32'h0);
            check("R7 sclk high cycles", 32'(hi_cyc - h0), wired ? 32'(nb * (DIVV + 1)) : 32'h0);
            check("R9 cs activity", 32'(fall_cs - f0), wired ? 32'h1 : 32'h0);
            if (wired) check("R7 mosi bits", got & m, exp_got);
            check("R10 tx_dreq", {31'd0, tx_dreq}, {31'd0, vc.mode != 2'd1});
            check("R10 rx_dreq", {31'd0, rx_dreq}, {31'd0, vc.mode != 2'd2});
            prev_rx = exp_rx;
        end
        solo_mode = 1'b0;

        // R3 disabled channel does not start; enable rising attempts
        wr(3'd2, 32'h0);
        rd_rx(v);
        wr(3'd0, (32'd7 << 7) | (32'(DIVV) << 2));
        slv_word = 32'h0F; slv_n = 8;
        f0 = fall_cs;
        wr(3'd3, 32'h5A);
        repeat (20) @(negedge clk);
        check("R3 no start while disabled", 32'(fall_cs - f0), 32'h0);
        peek(3'd1, v); check("R4 txs cleared by write", v & 32'h3, 32'h0);
        wr(3'd2, 32'h1);
        wait_done();
        check("R3 enable rise starts", 32'(fall_cs - f0), 32'h1);
        check("R3 word sent", got & 32'hFF, 32'h5A);

        // R5 blocked by receive-full with turbo off
        f0 = fall_cs;
        wr(3'd3, 32'h11);
        repeat (20) @(negedge clk);
        check("R5 blocked by rxs", 32'(fall_cs - f0), 32'h0);
        peek(3'd1, v); check("R5 status blocked", v, 32'h5);
        // R4 receive read returns word and retries
        slv_word = 32'h66;
        rd_rx(v); check("R4 rx read value", v, 32'h0F);
        wait_done();
        check("R4 read attempts", 32'(fall_cs - f0), 32'h1);
        check("R4 retried word", got & 32'hFF, 32'h11);

        // R5 turbo lets a word go with receive-full set; R6 eot clears at start
        wr(3'd0, (32'h1 << 19) | (32'd7 << 7) | (32'(DIVV) << 2));
        f0 = fall_cs;
        wr(3'd3, 32'h22);
        repeat (4) @(negedge clk);
        peek(3'd1, v); check("R6 eot clear in flight", v & 32'h4, 32'h0);
        wait_done();
        check("R5 turbo start", 32'(fall_cs - f0), 32'h1);

        // R11 event pulses around one duplex word
        wr(3'd0, (32'd7 << 7) | (32'(DIVV) << 2));
        rd_rx(v);
        repeat (3) @(negedge clk);
        t0 = txe_cnt; x0 = rxf_cnt;
        wr(3'd3, 32'h33);
        wait_done();
        check("R11 tx event count", 32'(txe_cnt - t0), 32'h1);
        check("R11 rx event count", 32'(rxf_cnt - x0), 32'h1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule